// File: doc/BRIEF.md
# Smart-LED Serial Pulse Encoder

This block drives a single-wire chain of addressable LEDs. Each word written to it goes into a small queue. An encoder takes words from the queue and sends each one as a series of fixed-length bit periods, most significant bit first. Every period starts with the line high and drops it low after a high time that depends on the bit value. The total period, the high time for a zero and the high time for a one are all counted in ticks of a selectable prescaler, where one tick lasts D = 2^(presc_sel+1) clock cycles.

A frame is either the low 24 bits of a word or all 32 bits. If `strobe_mode` is set when a word is written, the queue entry becomes a latch command: the encoder holds the line low for 127 full bit periods and only then takes the next entry. Because pixel data and latch commands share one queue, software can queue a whole refresh, including its closing latch, in a single pass. Status outputs report the queue fill level and transmitter activity, and the interrupt condition can be selected.

The encoder FSM has three states. `S_IDLE` waits for an entry. The transition `take_data` moves it to `S_BIT`, and the transition `take_latch` moves it to `S_LATCH`. In `S_BIT`, the transition `next_bit` stays in the state and `frame_done` returns to `S_IDLE`. In `S_LATCH`, the transition `next_period` stays in the state and `latch_done` returns to `S_IDLE`. The transition `disable` returns from any state to `S_IDLE`.

Top module: `smartled_tx`

## Requirements
- R1: After reset, `led_out`=0, `tx_busy`=0, `fifo_empty`=1, `fifo_half`=0 and `fifo_full`=0.
- R2: A one bit is high for t_one_hi·D cycles and a zero bit for t_zero_hi·D cycles. Consecutive bits of a frame start t_total·D cycles apart, where D = 2^(presc_sel+1).
- R3: Bits are sent MSB first. With `wide_mode`=0, wr_data[23:0] is sent as 24 bits. With `wide_mode`=1, all 32 bits are sent.
- R4: A word written while `strobe_mode`=1 queues a latch command. For it, `tx_busy` stays high for exactly 127·t_total·D cycles with `led_out` low throughout.
- R5: `fifo_empty` means the count is 0. `fifo_half` means count ≥ DEPTH/2. `fifo_full` means count = DEPTH. Full implies half, and full and empty are never set together.
- R6: A write made while the queue is full is dropped. Accepted entries are sent in write order.
- R7: With `irq_on_empty`=0, `irq` = enable && count < DEPTH/2. With `irq_on_empty`=1, `irq` = enable && empty.
- R8: With `enable` low, the queue is flushed, the encoder is idle, `led_out`, `tx_busy` and `irq` are 0, and writes are ignored.
- R9: `depth_log2` equals the FIFO_LOG2 parameter.
- R10: For a data entry, `tx_busy` is high for exactly bits·t_total·D cycles, counted from the cycle the entry is taken. `led_out` is low whenever `tx_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; when low, the queue is flushed |
| wide_mode | input | 1 | 0: 24-bit frames, 1: 32-bit frames |
| strobe_mode | input | 1 | Set at write time to queue a latch command |
| presc_sel | input | 3 | Tick length select, D = 2^(sel+1) cycles |
| t_total | input | 5 | Ticks per bit period |
| t_zero_hi | input | 5 | High ticks for a zero |
| t_one_hi | input | 5 | High ticks for a one |
| irq_on_empty | input | 1 | Interrupt condition select |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to queue |
| depth_log2 | output | 4 | log2 of queue depth |
| fifo_empty | output | 1 | Queue empty |
| fifo_half | output | 1 | Queue at least half full |
| fifo_full | output | 1 | Queue full |
| tx_busy | output | 1 | Encoder is sending an entry |
| irq | output | 1 | Interrupt request |
| led_out | output | 1 | Serial line to the LED chain |

## Verification
The hardest state to reach from the ports is a full queue with a write still arriving. While enabled, the encoder immediately removes the first entry, and disabling the block flushes the queue. The stimulus therefore writes DEPTH+2 words on consecutive cycles while one frame is being sent. It then checks the full flag and the interrupt, decodes every pulse on `led_out` back into bits, and confirms that exactly the first DEPTH+1 words appear, in order. Latch duration and bit timing are measured in cycles between line edges, so they do not depend on where the prescaler phase happens to sit.

// File: rtl/smartled_pkg.sv
package smartled_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BIT   = 2'd1,
        S_LATCH = 2'd2
    } enc_state_t;

    localparam int WORD_W      = 32;
    localparam int NARROW_W    = 24;
    localparam int LATCH_PERIODS = 127;
endpackage

// File: rtl/smartled_fifo.sv
module smartled_fifo #(
    parameter int LOG2 = 2,
    parameter int W    = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         half,
    output logic         full
);
    localparam int DEPTH = 1 << LOG2;

    logic [W-1:0]  mem [DEPTH];
    logic [LOG2-1:0] wptr, rptr;
    logic [LOG2:0]   cnt;
    logic do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (LOG2+1)'(DEPTH));
    assign half    = (cnt >= (LOG2+1)'(DEPTH/2));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            cnt <= cnt + (LOG2+1)'(do_push) - (LOG2+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end
endmodule

// File: rtl/smartled_tick.sv
module smartled_tick #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) + 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(2) << sel) - CNT_W'(1);
    assign tick  = !clr && (pcnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pcnt <= '0;
        else if (clr || tick) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/smartled_enc.sv
module smartled_enc
    import smartled_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [TW-1:0]     t_total,
    input  logic [TW-1:0]     t_zero_hi,
    input  logic [TW-1:0]     t_one_hi,
    input  logic              wide_mode,
    input  logic              entry_valid,
    input  logic              entry_latch,
    input  logic [WORD_W-1:0] entry_word,
    output logic              entry_pop,
    output logic              busy,
    output logic              line
);
    localparam int BC_W = $clog2(WORD_W);
    localparam int PC_W = $clog2(LATCH_PERIODS + 1);

    enc_state_t state, nxt;
    logic [TW-1:0]     tcnt;
    logic [WORD_W-1:0] shreg;
    logic [BC_W-1:0]   bits_left;
    logic [PC_W-1:0]   periods;
    logic              period_end;
    logic [TW-1:0]     hi_ticks;

    assign period_end = tick && (({1'b0, tcnt} + (TW+1)'(1)) >= {1'b0, t_total});
    assign hi_ticks   = shreg[WORD_W-1] ? t_one_hi : t_zero_hi;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (entry_valid) nxt = entry_latch ? S_LATCH : S_BIT;
                S_BIT:   if (period_end && bits_left == '0) nxt = S_IDLE;
                S_LATCH: if (period_end && periods == PC_W'(LATCH_PERIODS - 1)) nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        entry_pop = enable && (state == S_IDLE) && entry_valid;
        busy      = (state != S_IDLE);
        line      = (state == S_BIT) && (tcnt < hi_ticks);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            shreg     <= '0;
            bits_left <= '0;
            periods   <= '0;
        end else if (state == S_IDLE || !enable) begin
            tcnt    <= '0;
            periods <= '0;
            if (entry_pop) begin
                shreg     <= wide_mode ? entry_word
                                       : {entry_word[NARROW_W-1:0], {(WORD_W-NARROW_W){1'b0}}};
                bits_left <= wide_mode ? BC_W'(WORD_W - 1) : BC_W'(NARROW_W - 1);
            end
        end else if (period_end) begin
            tcnt <= '0;
            if (state == S_BIT) begin
                shreg     <= shreg << 1;
                bits_left <= bits_left - 1'b1;
            end else begin
                periods <= periods + 1'b1;
            end
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/smartled_tx.sv
module smartled_tx #(
    parameter int FIFO_LOG2 = 2,
    parameter int TW        = 5,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wide_mode,
    input  logic             strobe_mode,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [TW-1:0]    t_total,
    input  logic [TW-1:0]    t_zero_hi,
    input  logic [TW-1:0]    t_one_hi,
    input  logic             irq_on_empty,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [3:0]       depth_log2,
    output logic             fifo_empty,
    output logic             fifo_half,
    output logic             fifo_full,
    output logic             tx_busy,
    output logic             irq,
    output logic             led_out
);
    localparam int ENTRY_W = 33;

    logic [ENTRY_W-1:0] head;
    logic pop, tick;

    assign depth_log2 = 4'(FIFO_LOG2);

    smartled_fifo #(.LOG2(FIFO_LOG2), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!enable),
        .push  (wr_en),
        .din   ({strobe_mode, wr_data}),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .half  (fifo_half),
        .full  (fifo_full)
    );

    smartled_tick #(.SEL_W(SEL_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!tx_busy),
        .sel   (presc_sel),
        .tick  (tick)
    );

    smartled_enc #(.TW(TW)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tick        (tick),
        .t_total     (t_total),
        .t_zero_hi   (t_zero_hi),
        .t_one_hi    (t_one_hi),
        .wide_mode   (wide_mode),
        .entry_valid (!fifo_empty),
        .entry_latch (head[ENTRY_W-1]),
        .entry_word  (head[31:0]),
        .entry_pop   (pop),
        .busy        (tx_busy),
        .line        (led_out)
    );

    assign irq = enable && (irq_on_empty ? fifo_empty : !fifo_half);
endmodule

// File: rtl/smartled_tx_chk.sv
module smartled_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fifo_empty,
    input logic fifo_half,
    input logic fifo_full,
    input logic tx_busy,
    input logic led_out
);
    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R5
    full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_half);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !led_out);

    // R8
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fifo_empty && !tx_busy));

    // R10
    start_from_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(!fifo_empty));
endmodule

bind smartled_tx smartled_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fifo_empty (fifo_empty),
    .fifo_half  (fifo_half),
    .fifo_full  (fifo_full),
    .tx_busy    (tx_busy),
    .led_out    (led_out)
);

// File: tb/sim_smartled_tx.sv
module sim_smartled_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic clk = 0, rst_n = 0;
    logic enable = 0, wide_mode = 0, strobe_mode = 0, irq_on_empty = 0, wr_en = 0;
    logic [2:0] presc_sel = 0;
    logic [4:0] t_total = 0, t_zero_hi = 0, t_one_hi = 0;
    logic [31:0] wr_data = 0;
    logic [3:0] depth_log2;
    logic fifo_empty, fifo_half, fifo_full, tx_busy, irq, led_out;

    smartled_tx u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // line monitor
    longint rise_at [256];
    longint hi_len  [256];
    int     nb = 0;
    longint busy_rise = 0, busy_fall = 0;
    logic   pl = 0, pb = 0;
    always @(negedge clk) begin
        if (led_out && !pl && nb < 256) rise_at[nb] = cyc;
        if (!led_out && pl && nb < 256) begin hi_len[nb] = cyc - rise_at[nb]; nb++; end
        if (tx_busy && !pb) busy_rise = cyc;
        if (!tx_busy && pb) busy_fall = cyc;
        pl = led_out;
        pb = tx_busy;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d, input logic strobe);
        @(negedge clk);
        wr_en = 1; wr_data = d; strobe_mode = strobe;
        @(negedge clk);
        wr_en = 0; strobe_mode = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (tx_busy || !fifo_empty) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // {wide(1), sel(3), total(5), zero_hi(5), one_hi(5), data(32)}
    localparam logic [50:0] VEC [4] = '{
        {1'b0, 3'd0, 5'd6, 5'd2, 5'd4, 32'hFFA5_0F3C},
        {1'b1, 3'd1, 5'd8, 5'd3, 5'd6, 32'h8000_0001},
        {1'b1, 3'd2, 5'd5, 5'd1, 5'd3, 32'hDEAD_BEEF},
        {1'b0, 3'd0, 5'd3, 5'd1, 5'd2, 32'h0000_0000}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(led_out == 0, "R1 led_out", led_out, 0);
        chk(tx_busy == 0, "R1 tx_busy", tx_busy, 0);
        chk(fifo_empty == 1 && fifo_half == 0 && fifo_full == 0, "R1 flags",
            {fifo_empty, fifo_half, fifo_full}, 3'b100);
        // R9
        chk(depth_log2 == 2, "R9 depth_log2", depth_log2, 2);
        enable = 1;
        @(negedge clk);
        // R7 empty queue below half with irq_on_empty=0
        chk(irq == 1, "R7 irq below half", irq, 1);

        // table walk: R2 R3 R10
        for (int i = 0; i < 4; i++) begin
            automatic logic [50:0] v = VEC[i];
            automatic int w = v[50] ? 32 : 24;
            automatic longint d = longint'(2) << v[49:47];
            automatic longint tt = v[46:42];
            automatic longint t0 = v[41:37];
            automatic longint t1 = v[36:32];
            automatic int badbits = 0, badhi = 0, badper = 0;
            wide_mode = v[50]; presc_sel = v[49:47];
            t_total = v[46:42]; t_zero_hi = v[41:37]; t_one_hi = v[36:32];
            nb = 0;
            write_word(v[31:0], 0);
            wait_idle();
            // pulses: a zero bit with zero_hi>0 still pulses, so count = w
            chk(nb == w, "R3 pulse count", nb, w);
            for (int b = 0; b < w && b < nb; b++) begin
                automatic bit exp_b = v[w-1-b];
                automatic bit got_b = (hi_len[b] * 2 > (t0 + t1) * d);
                if (got_b != exp_b) badbits++;
                if (hi_len[b] != (exp_b ? t1 : t0) * d) badhi++;
                if (b > 0 && rise_at[b] - rise_at[b-1] != tt * d) badper++;
            end
            chk(badbits == 0, "R3 msb-first bits", badbits, 0);
            chk(badhi == 0, "R2 high times", badhi, 0);
            chk(badper == 0, "R2 bit periods", badper, 0);
            chk(busy_fall - busy_rise == w * tt * d, "R10 busy length",
                busy_fall - busy_rise, w * tt * d);
        end

        // R4 latch command
        wide_mode = 0; presc_sel = 1; t_total = 3; t_zero_hi = 1; t_one_hi = 2;
        nb = 0;
        write_word(32'hFFFF_FFFF, 1);
        wait_idle();
        chk(nb == 0, "R4 line stays low", nb, 0);
        chk(busy_fall - busy_rise == 127 * 3 * 4, "R4 latch length",
            busy_fall - busy_rise, 127 * 3 * 4);

        // R5 R6 R7 full queue and dropped write
        presc_sel = 0; t_total = 4; t_zero_hi = 1; t_one_hi = 3; irq_on_empty = 0;
        nb = 0;
        @(negedge clk);
        for (int k = 0; k < DEPTH + 2; k++) begin
            wr_en = 1; wr_data = 32'h0010_0001 * (k + 1) + 32'h0000_8000; strobe_mode = 0;
            @(negedge clk);
        end
        wr_en = 0;
        chk(fifo_full == 1, "R5 full flag", fifo_full, 1);
        chk(fifo_half == 1 && fifo_empty == 0, "R5 half/empty flags",
            {fifo_half, fifo_empty}, 2'b10);
        chk(irq == 0, "R7 irq at full", irq, 0);
        wait_idle();
        begin
            automatic int bad = 0;
            chk(nb == 24 * (DEPTH + 1), "R6 drop: pulse count", nb, 24 * (DEPTH + 1));
            for (int f = 0; f < DEPTH + 1; f++)
                for (int b = 0; b < 24; b++) begin
                    automatic logic [31:0] wd = 32'h0010_0001 * (f + 1) + 32'h0000_8000;
                    automatic int idx = f * 24 + b;
                    if (idx < nb && ((hi_len[idx] * 2 > 8) != wd[23-b])) bad++;
                end
            chk(bad == 0, "R6 order of sent entries", bad, 0);
        end

        // R7 empty-mode interrupt
        irq_on_empty = 1;
        @(negedge clk);
        chk(irq == 1, "R7 irq on empty", irq, 1);
        write_word(32'h0, 0);
        write_word(32'h0, 0);
        chk(irq == 0, "R7 irq not empty", irq, 0);

        // R8 disable flushes and ignores writes
        enable = 0;
        @(negedge clk);
        chk(fifo_empty && !tx_busy && !led_out && !irq, "R8 flushed",
            {fifo_empty, tx_busy, led_out, irq}, 4'b1000);
        write_word(32'h1234_5678, 0);
        chk(fifo_empty == 1, "R8 write ignored", fifo_empty, 1);
        enable = 1;
        @(negedge clk);
        chk(tx_busy == 0 && irq == 1, "R8 nothing queued after enable",
            {tx_busy, irq}, 2'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule